// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps the ordering state of a fixed pool of memory groups for an out-of-order core's load/store scheduling. A group collects memory operations that do not depend on each other but share the same older dependencies. Each slot holds counters for its predecessors and for its own instructions, plus a bit vector that names its successor groups. When a group starts or finishes, its successors are updated in the same clock edge, so the scheduler can ask whether any group must still wait, may start speculatively (pending), or is free to issue (ready).

One event enters per cycle on a small command port. The event carries an operation code, a group ID, a second ID for edges and a remaining-cycle count for issues. A separate query port picks any group and returns its status flags and a critical-path estimate, which is the largest remaining-cycle figure reported by a predecessor. That estimate counts down while the group waits. An illegal event leaves every counter alone and sets a sticky error flag.

Top module: `mdg_tracker`

## Requirements
- R1: After reset `next_gid` is 1, `err` is 0 and every query returns `q_valid`=0 with all status flags and `q_crit` at 0. ID 0, IDs above the pool size and IDs not yet allocated always return `q_valid`=0 with zero outputs.
- R2: Allocation (op 1) hands out the value on `next_gid`, starting at 1 and rising by one per allocation. When all `NG` slots are in use, a further allocation sets `err` and leaves `next_gid` unchanged.
- R3: Predecessor status of a group: waiting when predecessors > executing-predecessors + executed-predecessors; pending when executing-predecessors is nonzero and the sum equals the predecessor count; ready when executed-predecessors equals the predecessor count.
- R4: Instruction status of a group: executing when its executing count is nonzero and equals instructions minus executed; executed when executed equals instructions. Add-instruction (op 2) increases the instruction count by one.
- R5: Issue (op 4) raises the group's executing count. When that issue puts the group into the executing state, every successor's executing-predecessor count rises by one. Issue is legal only for a ready group that still has unissued instructions.
- R6: Execute (op 5) moves one instruction from executing to executed. When the group's last instruction completes, each successor moves one predecessor from executing to executed.
- R7: Add-successor (op 3, `ev_gid` to `ev_dst`) raises the successor's predecessor count. If the source group is executing, it also counts at once as an issued predecessor for the successor. The event is illegal if the source has already executed, the edge already exists, the two IDs are equal, or the successor has issued instructions.
- R8: Each issued-predecessor event sets the successor's critical count to the larger of the stored value and the source's largest issued remaining-cycle value. A tick (op 6) decrements the count of every group that is waiting and has a nonzero count; other groups keep theirs.
- R9: Add-instruction to a group that already has a successor is illegal.
- R10: Illegal events set `err`, which stays set until reset, and change no counter. Ops 0 and 7 are illegal. So are events on an invalid ID and an execute on a group with no executing instruction.
- R11: Query outputs follow `q_gid` combinationally. An event presented with `ev_valid` takes effect at the next rising clock edge, and with no event the queried status does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_op | input | 3 | Event code: 1 alloc, 2 add instruction, 3 add successor, 4 issue, 5 execute, 6 tick |
| ev_gid | input | GID_W | Group the event applies to (edge source for op 3) |
| ev_dst | input | GID_W | Successor group for op 3 |
| ev_cyc | input | CYC_W | Remaining cycles of the issued instruction (op 4) |
| next_gid | output | GID_W | ID the next allocation returns |
| q_gid | input | GID_W | Group selected for query |
| q_valid | output | 1 | Selected ID names an allocated group |
| q_waiting | output | 1 | Selected group is waiting |
| q_pending | output | 1 | Selected group is pending |
| q_ready | output | 1 | Selected group is ready |
| q_executing | output | 1 | Selected group is executing |
| q_executed | output | 1 | Selected group has executed |
| q_crit | output | CYC_W | Critical predecessor remaining cycles |
| err | output | 1 | Sticky illegal-event flag |

## Verification
The bench follows a three-group chain through waiting, pending, ready, executing and executed. It attaches an edge to a source group that is already executing, and it ticks while a group waits and again after the group has left waiting. A design that forgot the late-edge propagation would report the successor as waiting with a zero critical count. A design that ticked unconditionally would lose cycles on ready groups. A design that propagated on the first issue rather than on the last would show pending one cycle too early. Illegal events are checked by reading back the queried status, which must show unchanged counters, together with the sticky flag. Pool exhaustion and the reserved codes are also covered, and so is the timing of the edge: no change before the clock, a change after it.

// File: rtl/mdg_pkg.sv
package mdg_pkg;

   localparam int CNT_MAX_W = 16;

   typedef enum logic [2:0] {
      OP_NONE     = 3'd0,
      OP_ALLOC    = 3'd1,
      OP_ADD_INSN = 3'd2,
      OP_ADD_SUCC = 3'd3,
      OP_ISSUE    = 3'd4,
      OP_EXEC     = 3'd5,
      OP_TICK     = 3'd6,
      OP_RSVD     = 3'd7
   } mdg_op_e;

   typedef struct packed {
      logic waiting;
      logic pending;
      logic ready;
      logic executing;
      logic executed;
   } mdg_stat_t;

   // Status flags from the six counters of one slot (zero-extended to 16 bits).
   function automatic mdg_stat_t grp_status(
      input logic [CNT_MAX_W-1:0] pred,
      input logic [CNT_MAX_W-1:0] pexec,
      input logic [CNT_MAX_W-1:0] pdone,
      input logic [CNT_MAX_W-1:0] insn,
      input logic [CNT_MAX_W-1:0] exec,
      input logic [CNT_MAX_W-1:0] done);
      mdg_stat_t s;
      logic [CNT_MAX_W:0] psum;
      psum        = {1'b0, pexec} + {1'b0, pdone};
      s.waiting   = {1'b0, pred} > psum;
      s.pending   = (pexec != '0) && (psum == {1'b0, pred});
      s.ready     = (pdone == pred);
      s.executing = (exec != '0) && (exec == (insn - done));
      s.executed  = (insn == done);
      return s;
   endfunction

endpackage

// File: rtl/mdg_slot.sv
module mdg_slot
   import mdg_pkg::*;
#(
   parameter int NG         = 8,
   parameter int CNT_W      = 4,
   parameter int CYC_W      = 6,
   parameter int IDX        = 0,
   parameter bit TRACK_CRIT = 1'b1,
   localparam int IDX_W     = $clog2(NG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_alloc,
   input  logic             do_insn,
   input  logic             do_succ,
   input  logic             do_issue,
   input  logic             do_exec,
   input  logic             do_tick,
   input  logic [IDX_W-1:0] src_idx,
   input  logic [IDX_W-1:0] dst_idx,
   input  logic             src_enter,
   input  logic             src_finish,
   input  logic             src_execing,
   input  logic             hit,
   input  logic [CYC_W-1:0] bcast_cyc,
   input  logic [CYC_W-1:0] src_mem_new,
   output logic             valid_o,
   output logic [CNT_W-1:0] pred_o,
   output logic [CNT_W-1:0] pexec_o,
   output logic [CNT_W-1:0] pdone_o,
   output logic [CNT_W-1:0] insn_o,
   output logic [CNT_W-1:0] exec_o,
   output logic [CNT_W-1:0] done_o,
   output logic [NG-1:0]    succ_o,
   output logic [CYC_W-1:0] mem_o,
   output logic [CYC_W-1:0] crit_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             valid_q;
   logic [CNT_W-1:0] pred_q, pexec_q, pdone_q, insn_q, exec_q, done_q;
   logic [NG-1:0]    succ_q;
   logic [CYC_W-1:0] mem_q, crit_q;

   logic      is_src, is_dst, pexec_inc, pexec_dec;
   mdg_stat_t st;

   assign is_src    = (src_idx == IDX_W'(IDX));
   assign is_dst    = (dst_idx == IDX_W'(IDX));
   assign pexec_inc = (do_issue && src_enter && hit) || (do_succ && is_dst && src_execing);
   assign pexec_dec = do_exec && src_finish && hit;
   assign st        = grp_status(CNT_MAX_W'(pred_q), CNT_MAX_W'(pexec_q), CNT_MAX_W'(pdone_q),
                                 CNT_MAX_W'(insn_q), CNT_MAX_W'(exec_q), CNT_MAX_W'(done_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pred_q  <= '0;
         pexec_q <= '0;
         pdone_q <= '0;
         insn_q  <= '0;
         exec_q  <= '0;
         done_q  <= '0;
         succ_q  <= '0;
      end else begin
         if (do_alloc && is_src) valid_q <= 1'b1;
         if (do_insn && is_src)  insn_q  <= insn_q + ONE;
         if (do_succ && is_src)  succ_q[dst_idx] <= 1'b1;
         if (do_succ && is_dst)  pred_q  <= pred_q + ONE;
         if (pexec_inc)          pexec_q <= pexec_q + ONE;
         else if (pexec_dec)     pexec_q <= pexec_q - ONE;
         if (pexec_dec)          pdone_q <= pdone_q + ONE;
         if (do_issue && is_src) exec_q  <= exec_q + ONE;
         else if (do_exec && is_src) begin
            exec_q <= exec_q - ONE;
            done_q <= done_q + ONE;
         end
      end
   end

   generate
      if (TRACK_CRIT) begin : g_crit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_q  <= '0;
               crit_q <= '0;
            end else begin
               if (do_issue && is_src) mem_q <= src_mem_new;
               if (pexec_inc) begin
                  if (bcast_cyc > crit_q) crit_q <= bcast_cyc;
               end else if (do_tick && st.waiting && (crit_q != '0)) begin
                  crit_q <= crit_q - CYC_W'(1);
               end
            end
         end
      end else begin : g_nocrit
         assign mem_q  = '0;
         assign crit_q = '0;
      end
   endgenerate

   assign valid_o = valid_q;
   assign pred_o  = pred_q;
   assign pexec_o = pexec_q;
   assign pdone_o = pdone_q;
   assign insn_o  = insn_q;
   assign exec_o  = exec_q;
   assign done_o  = done_q;
   assign succ_o  = succ_q;
   assign mem_o   = mem_q;
   assign crit_o  = crit_q;

endmodule

// File: rtl/mdg_decode.sv
module mdg_decode
   import mdg_pkg::*;
#(
   parameter int NG     = 8,
   parameter int CNT_W  = 4,
   parameter int CYC_W  = 6,
   localparam int IDX_W = $clog2(NG),
   localparam int GID_W = $clog2(NG + 2)
) (
   input  logic             ev_valid,
   input  logic [2:0]       ev_op,
   input  logic [GID_W-1:0] ev_gid,
   input  logic [GID_W-1:0] ev_dst,
   input  logic [CYC_W-1:0] ev_cyc,
   input  logic [GID_W-1:0] next_id,
   input  logic             valid_a [NG],
   input  logic [CNT_W-1:0] pred_a  [NG],
   input  logic [CNT_W-1:0] pexec_a [NG],
   input  logic [CNT_W-1:0] pdone_a [NG],
   input  logic [CNT_W-1:0] insn_a  [NG],
   input  logic [CNT_W-1:0] exec_a  [NG],
   input  logic [CNT_W-1:0] done_a  [NG],
   input  logic [NG-1:0]    succ_a  [NG],
   input  logic [CYC_W-1:0] mem_a   [NG],
   output logic             do_alloc,
   output logic             do_insn,
   output logic             do_succ,
   output logic             do_issue,
   output logic             do_exec,
   output logic             do_tick,
   output logic             ev_bad,
   output logic [IDX_W-1:0] src_idx,
   output logic [IDX_W-1:0] dst_idx,
   output logic             src_enter,
   output logic             src_finish,
   output logic             src_execing,
   output logic [NG-1:0]    src_succ,
   output logic [CYC_W-1:0] bcast_cyc,
   output logic [CYC_W-1:0] src_mem_new
);

   localparam logic [GID_W-1:0] NG_ID = GID_W'(NG);

   logic             g_in, d_in, g_ok, d_ok, legal, has_free;
   logic [IDX_W-1:0] g_idx, d_idx;
   logic [CNT_W:0]   g_busy, g_left;
   mdg_stat_t        sg;
   mdg_op_e          op;

   assign op    = mdg_op_e'(ev_op);
   assign g_in  = (ev_gid != '0) && (ev_gid <= NG_ID);
   assign d_in  = (ev_dst != '0) && (ev_dst <= NG_ID);
   assign g_idx = g_in ? IDX_W'(ev_gid - GID_W'(1)) : '0;
   assign d_idx = d_in ? IDX_W'(ev_dst - GID_W'(1)) : '0;
   assign g_ok  = g_in && valid_a[g_idx];
   assign d_ok  = d_in && valid_a[d_idx];
   assign has_free = (next_id <= NG_ID);

   assign sg = grp_status(CNT_MAX_W'(pred_a[g_idx]), CNT_MAX_W'(pexec_a[g_idx]),
                          CNT_MAX_W'(pdone_a[g_idx]), CNT_MAX_W'(insn_a[g_idx]),
                          CNT_MAX_W'(exec_a[g_idx]), CNT_MAX_W'(done_a[g_idx]));

   // in-flight plus finished instructions, and the remainder
   assign g_busy = {1'b0, exec_a[g_idx]} + {1'b0, done_a[g_idx]};
   assign g_left = {1'b0, insn_a[g_idx]} - {1'b0, done_a[g_idx]};

   always_comb begin
      legal = 1'b0;
      if (ev_valid) begin
         case (op)
            OP_ALLOC:    legal = has_free;
            OP_ADD_INSN: legal = g_ok && (succ_a[g_idx] == '0) && (insn_a[g_idx] != '1);
            OP_ADD_SUCC: legal = g_ok && d_ok && (ev_gid != ev_dst) && !sg.executed &&
                                 !succ_a[g_idx][d_idx] && (pred_a[d_idx] != '1) &&
                                 (exec_a[d_idx] == '0) && (done_a[d_idx] == '0);
            OP_ISSUE:    legal = g_ok && sg.ready && (g_busy < {1'b0, insn_a[g_idx]});
            OP_EXEC:     legal = g_ok && (exec_a[g_idx] != '0);
            OP_TICK:     legal = 1'b1;
            default:     legal = 1'b0;
         endcase
      end
   end

   assign ev_bad   = ev_valid && !legal;
   assign do_alloc = legal && (op == OP_ALLOC);
   assign do_insn  = legal && (op == OP_ADD_INSN);
   assign do_succ  = legal && (op == OP_ADD_SUCC);
   assign do_issue = legal && (op == OP_ISSUE);
   assign do_exec  = legal && (op == OP_EXEC);
   assign do_tick  = legal && (op == OP_TICK);

   assign src_idx     = (op == OP_ALLOC) ? IDX_W'(next_id - GID_W'(1)) : g_idx;
   assign dst_idx     = d_idx;
   assign src_enter   = (({1'b0, exec_a[g_idx]} + (CNT_W+1)'(1)) == g_left);
   assign src_finish  = (({1'b0, done_a[g_idx]} + (CNT_W+1)'(1)) == {1'b0, insn_a[g_idx]});
   assign src_execing = sg.executing;
   assign src_succ    = succ_a[g_idx];
   assign src_mem_new = (ev_cyc > mem_a[g_idx]) ? ev_cyc : mem_a[g_idx];
   assign bcast_cyc   = (op == OP_ISSUE) ? src_mem_new : mem_a[g_idx];

endmodule

// File: rtl/mdg_query.sv
module mdg_query
   import mdg_pkg::*;
#(
   parameter int NG     = 8,
   parameter int CNT_W  = 4,
   parameter int CYC_W  = 6,
   localparam int IDX_W = $clog2(NG),
   localparam int GID_W = $clog2(NG + 2)
) (
   input  logic [GID_W-1:0] q_gid,
   input  logic             valid_a [NG],
   input  logic [CNT_W-1:0] pred_a  [NG],
   input  logic [CNT_W-1:0] pexec_a [NG],
   input  logic [CNT_W-1:0] pdone_a [NG],
   input  logic [CNT_W-1:0] insn_a  [NG],
   input  logic [CNT_W-1:0] exec_a  [NG],
   input  logic [CNT_W-1:0] done_a  [NG],
   input  logic [CYC_W-1:0] crit_a  [NG],
   output logic             q_valid,
   output mdg_stat_t        q_stat,
   output logic [CYC_W-1:0] q_crit
);

   logic             in_rng;
   logic [IDX_W-1:0] qi;
   mdg_stat_t        raw;

   assign in_rng  = (q_gid != '0) && (q_gid <= GID_W'(NG));
   assign qi      = in_rng ? IDX_W'(q_gid - GID_W'(1)) : '0;
   assign q_valid = in_rng && valid_a[qi];
   assign raw     = grp_status(CNT_MAX_W'(pred_a[qi]), CNT_MAX_W'(pexec_a[qi]),
                               CNT_MAX_W'(pdone_a[qi]), CNT_MAX_W'(insn_a[qi]),
                               CNT_MAX_W'(exec_a[qi]), CNT_MAX_W'(done_a[qi]));
   assign q_stat  = q_valid ? raw : '0;
   assign q_crit  = q_valid ? crit_a[qi] : '0;

endmodule

// File: rtl/mdg_tracker.sv
module mdg_tracker
   import mdg_pkg::*;
#(
   parameter int NG         = 8,
   parameter int CNT_W      = 4,
   parameter int CYC_W      = 6,
   parameter bit TRACK_CRIT = 1'b1,
   localparam int IDX_W     = $clog2(NG),
   localparam int GID_W     = $clog2(NG + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   input  logic [2:0]       ev_op,
   input  logic [GID_W-1:0] ev_gid,
   input  logic [GID_W-1:0] ev_dst,
   input  logic [CYC_W-1:0] ev_cyc,
   output logic [GID_W-1:0] next_gid,
   input  logic [GID_W-1:0] q_gid,
   output logic             q_valid,
   output logic             q_waiting,
   output logic             q_pending,
   output logic             q_ready,
   output logic             q_executing,
   output logic             q_executed,
   output logic [CYC_W-1:0] q_crit,
   output logic             err
);

   generate
      if (NG < 2 || NG > 256) begin : g_bad_ng
         $error("mdg_tracker: NG must lie in 2..256");
      end
      if (CNT_W < 2 || CNT_W > CNT_MAX_W) begin : g_bad_cnt
         $error("mdg_tracker: CNT_W must lie in 2..16");
      end
      if (CYC_W < 1) begin : g_bad_cyc
         $error("mdg_tracker: CYC_W must be positive");
      end
   endgenerate

   logic             valid_a [NG];
   logic [CNT_W-1:0] pred_a  [NG];
   logic [CNT_W-1:0] pexec_a [NG];
   logic [CNT_W-1:0] pdone_a [NG];
   logic [CNT_W-1:0] insn_a  [NG];
   logic [CNT_W-1:0] exec_a  [NG];
   logic [CNT_W-1:0] done_a  [NG];
   logic [NG-1:0]    succ_a  [NG];
   logic [CYC_W-1:0] mem_a   [NG];
   logic [CYC_W-1:0] crit_a  [NG];

   logic             do_alloc, do_insn, do_succ, do_issue, do_exec, do_tick, ev_bad;
   logic [IDX_W-1:0] src_idx, dst_idx;
   logic             src_enter, src_finish, src_execing;
   logic [NG-1:0]    src_succ;
   logic [CYC_W-1:0] bcast_cyc, src_mem_new;
   logic [GID_W-1:0] next_q;
   logic             err_q;
   mdg_stat_t        q_stat;

   mdg_decode #(.NG(NG), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_dec (
      .ev_valid    (ev_valid),
      .ev_op       (ev_op),
      .ev_gid      (ev_gid),
      .ev_dst      (ev_dst),
      .ev_cyc      (ev_cyc),
      .next_id     (next_q),
      .valid_a     (valid_a),
      .pred_a      (pred_a),
      .pexec_a     (pexec_a),
      .pdone_a     (pdone_a),
      .insn_a      (insn_a),
      .exec_a      (exec_a),
      .done_a      (done_a),
      .succ_a      (succ_a),
      .mem_a       (mem_a),
      .do_alloc    (do_alloc),
      .do_insn     (do_insn),
      .do_succ     (do_succ),
      .do_issue    (do_issue),
      .do_exec     (do_exec),
      .do_tick     (do_tick),
      .ev_bad      (ev_bad),
      .src_idx     (src_idx),
      .dst_idx     (dst_idx),
      .src_enter   (src_enter),
      .src_finish  (src_finish),
      .src_execing (src_execing),
      .src_succ    (src_succ),
      .bcast_cyc   (bcast_cyc),
      .src_mem_new (src_mem_new)
   );

   generate
      for (genvar k = 0; k < NG; k++) begin : g_slot
         mdg_slot #(
            .NG(NG), .CNT_W(CNT_W), .CYC_W(CYC_W), .IDX(k), .TRACK_CRIT(TRACK_CRIT)
         ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .do_alloc    (do_alloc),
            .do_insn     (do_insn),
            .do_succ     (do_succ),
            .do_issue    (do_issue),
            .do_exec     (do_exec),
            .do_tick     (do_tick),
            .src_idx     (src_idx),
            .dst_idx     (dst_idx),
            .src_enter   (src_enter),
            .src_finish  (src_finish),
            .src_execing (src_execing),
            .hit         (src_succ[k]),
            .bcast_cyc   (bcast_cyc),
            .src_mem_new (src_mem_new),
            .valid_o     (valid_a[k]),
            .pred_o      (pred_a[k]),
            .pexec_o     (pexec_a[k]),
            .pdone_o     (pdone_a[k]),
            .insn_o      (insn_a[k]),
            .exec_o      (exec_a[k]),
            .done_o      (done_a[k]),
            .succ_o      (succ_a[k]),
            .mem_o       (mem_a[k]),
            .crit_o      (crit_a[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q <= GID_W'(1);
         err_q  <= 1'b0;
      end else begin
         if (do_alloc) next_q <= next_q + GID_W'(1);
         if (ev_bad)   err_q  <= 1'b1;
      end
   end

   mdg_query #(.NG(NG), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_qry (
      .q_gid   (q_gid),
      .valid_a (valid_a),
      .pred_a  (pred_a),
      .pexec_a (pexec_a),
      .pdone_a (pdone_a),
      .insn_a  (insn_a),
      .exec_a  (exec_a),
      .done_a  (done_a),
      .crit_a  (crit_a),
      .q_valid (q_valid),
      .q_stat  (q_stat),
      .q_crit  (q_crit)
   );

   assign next_gid    = next_q;
   assign err         = err_q;
   assign q_waiting   = q_stat.waiting;
   assign q_pending   = q_stat.pending;
   assign q_ready     = q_stat.ready;
   assign q_executing = q_stat.executing;
   assign q_executed  = q_stat.executed;

endmodule

// File: rtl/mdg_tracker_chk.sv
module mdg_tracker_chk
   import mdg_pkg::*;
#(
   parameter int NG     = 8,
   parameter int CYC_W  = 6,
   localparam int GID_W = $clog2(NG + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_valid,
   input logic [2:0]       ev_op,
   input logic [GID_W-1:0] next_gid,
   input logic [GID_W-1:0] q_gid,
   input logic             q_valid,
   input logic             q_waiting,
   input logic             q_pending,
   input logic             q_ready,
   input logic             q_executing,
   input logic             q_executed,
   input logic [CYC_W-1:0] q_crit,
   input logic             err
);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R10
   rsvd_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && (ev_op == OP_NONE || ev_op == OP_RSVD)) |=> err);

   // R2
   alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_op == OP_ALLOC && next_gid <= GID_W'(NG))
      |=> (next_gid == $past(next_gid) + GID_W'(1)));

   // R2
   alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_op == OP_ALLOC && next_gid > GID_W'(NG))
      |=> (err && $stable(next_gid)));

   // R1
   id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_gid == '0) |-> (!q_valid && !q_waiting && !q_pending && !q_ready &&
                         !q_executing && !q_executed && q_crit == '0));

   // R3
   wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_waiting |-> (!q_ready && !q_pending));

   // R8
   tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_op == OP_TICK && q_waiting && q_crit != '0)
      |=> ((q_gid != $past(q_gid)) || (q_crit == $past(q_crit) - CYC_W'(1))));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> ((q_gid != $past(q_gid)) ||
                     ($stable(q_ready) && $stable(q_waiting) && $stable(q_executing) &&
                      $stable(q_executed) && $stable(q_crit))));

endmodule

bind mdg_tracker mdg_tracker_chk #(.NG(NG), .CYC_W(CYC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev_valid    (ev_valid),
   .ev_op       (ev_op),
   .next_gid    (next_gid),
   .q_gid       (q_gid),
   .q_valid     (q_valid),
   .q_waiting   (q_waiting),
   .q_pending   (q_pending),
   .q_ready     (q_ready),
   .q_executing (q_executing),
   .q_executed  (q_executed),
   .q_crit      (q_crit),
   .err         (err)
);

// File: tb/tb_mdg_tracker.sv
module tb_mdg_tracker;

   localparam int NG    = 8;
   localparam int CNT_W = 4;
   localparam int CYC_W = 6;
   localparam int GID_W = $clog2(NG + 2);
   localparam int NV    = 33;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ev_valid = 1'b0;
   logic [2:0]       ev_op = '0;
   logic [GID_W-1:0] ev_gid = '0;
   logic [GID_W-1:0] ev_dst = '0;
   logic [CYC_W-1:0] ev_cyc = '0;
   logic [GID_W-1:0] next_gid;
   logic [GID_W-1:0] q_gid = '0;
   logic             q_valid, q_waiting, q_pending, q_ready, q_executing, q_executed;
   logic [CYC_W-1:0] q_crit;
   logic             err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mdg_tracker #(.NG(NG), .CNT_W(CNT_W), .CYC_W(CYC_W)) dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op), .ev_gid(ev_gid),
      .ev_dst(ev_dst), .ev_cyc(ev_cyc), .next_gid(next_gid), .q_gid(q_gid),
      .q_valid(q_valid), .q_waiting(q_waiting), .q_pending(q_pending), .q_ready(q_ready),
      .q_executing(q_executing), .q_executed(q_executed), .q_crit(q_crit), .err(err)
   );

   // fields: valid op gid dst cyc | qgid qvalid status{wait,pend,ready,exing,exed} crit err
   localparam logic [34:0] VEC [NV] = '{
      {1'b1,3'd1,4'd0,4'd0,6'd0, 4'd1,1'b1,5'b00101,6'd0,1'b0},
      {1'b1,3'd1,4'd0,4'd0,6'd0, 4'd2,1'b1,5'b00101,6'd0,1'b0},
      {1'b1,3'd1,4'd0,4'd0,6'd0, 4'd3,1'b1,5'b00101,6'd0,1'b0},
      {1'b1,3'd2,4'd1,4'd0,6'd0, 4'd1,1'b1,5'b00100,6'd0,1'b0},
      {1'b1,3'd2,4'd1,4'd0,6'd0, 4'd1,1'b1,5'b00100,6'd0,1'b0},
      {1'b1,3'd2,4'd2,4'd0,6'd0, 4'd2,1'b1,5'b00100,6'd0,1'b0},
      {1'b1,3'd2,4'd3,4'd0,6'd0, 4'd3,1'b1,5'b00100,6'd0,1'b0},
      {1'b1,3'd3,4'd1,4'd2,6'd0, 4'd2,1'b1,5'b10000,6'd0,1'b0},
      {1'b1,3'd3,4'd2,4'd3,6'd0, 4'd3,1'b1,5'b10000,6'd0,1'b0},
      {1'b1,3'd4,4'd1,4'd0,6'd5, 4'd1,1'b1,5'b00100,6'd0,1'b0},
      {1'b0,3'd0,4'd0,4'd0,6'd0, 4'd2,1'b1,5'b10000,6'd0,1'b0},
      {1'b1,3'd6,4'd0,4'd0,6'd0, 4'd1,1'b1,5'b00100,6'd0,1'b0},
      {1'b1,3'd4,4'd1,4'd0,6'd9, 4'd1,1'b1,5'b00110,6'd0,1'b0},
      {1'b0,3'd0,4'd0,4'd0,6'd0, 4'd2,1'b1,5'b01000,6'd9,1'b0},
      {1'b1,3'd6,4'd0,4'd0,6'd0, 4'd2,1'b1,5'b01000,6'd9,1'b0},
      {1'b0,3'd0,4'd0,4'd0,6'd0, 4'd3,1'b1,5'b10000,6'd0,1'b0},
      {1'b1,3'd3,4'd1,4'd3,6'd0, 4'd3,1'b1,5'b10000,6'd9,1'b0},
      {1'b1,3'd6,4'd0,4'd0,6'd0, 4'd3,1'b1,5'b10000,6'd8,1'b0},
      {1'b1,3'd5,4'd1,4'd0,6'd0, 4'd1,1'b1,5'b00110,6'd0,1'b0},
      {1'b1,3'd5,4'd1,4'd0,6'd0, 4'd1,1'b1,5'b00101,6'd0,1'b0},
      {1'b0,3'd0,4'd0,4'd0,6'd0, 4'd2,1'b1,5'b00100,6'd9,1'b0},
      {1'b0,3'd0,4'd0,4'd0,6'd0, 4'd3,1'b1,5'b10000,6'd8,1'b0},
      {1'b1,3'd4,4'd2,4'd0,6'd3, 4'd2,1'b1,5'b00110,6'd9,1'b0},
      {1'b0,3'd0,4'd0,4'd0,6'd0, 4'd3,1'b1,5'b01000,6'd8,1'b0},
      {1'b1,3'd5,4'd2,4'd0,6'd0, 4'd2,1'b1,5'b00101,6'd9,1'b0},
      {1'b0,3'd0,4'd0,4'd0,6'd0, 4'd3,1'b1,5'b00100,6'd8,1'b0},
      {1'b1,3'd6,4'd0,4'd0,6'd0, 4'd3,1'b1,5'b00100,6'd8,1'b0},
      {1'b1,3'd2,4'd1,4'd0,6'd0, 4'd1,1'b1,5'b00101,6'd0,1'b1},
      {1'b1,3'd3,4'd2,4'd3,6'd0, 4'd3,1'b1,5'b00100,6'd8,1'b1},
      {1'b1,3'd4,4'd2,4'd0,6'd7, 4'd2,1'b1,5'b00101,6'd9,1'b1},
      {1'b1,3'd5,4'd3,4'd0,6'd0, 4'd3,1'b1,5'b00100,6'd8,1'b1},
      {1'b1,3'd2,4'd0,4'd0,6'd0, 4'd0,1'b0,5'b00000,6'd0,1'b1},
      {1'b1,3'd4,4'd3,4'd0,6'd2, 4'd3,1'b1,5'b00110,6'd8,1'b1}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic v, input logic [2:0] op);
      if (!v) return "R3";
      case (op)
         3'd1:    return "R2";
         3'd2:    return "R4";
         3'd3:    return "R7";
         3'd4:    return "R5";
         3'd5:    return "R6";
         3'd6:    return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      ev_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // present one event for one edge, then go idle; returns at a negedge
   task automatic send(input logic [2:0] op, input logic [GID_W-1:0] g,
                       input logic [GID_W-1:0] d, input logic [CYC_W-1:0] c);
      @(negedge clk);
      ev_valid = 1'b1;
      ev_op    = op;
      ev_gid   = g;
      ev_dst   = d;
      ev_cyc   = c;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   function automatic logic [4:0] stat();
      return {q_waiting, q_pending, q_ready, q_executing, q_executed};
   endfunction

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [34:0] e;
      do_reset();
      #1;
      // R1 reset state
      check("R1", "next_gid after reset", 32'(next_gid), 32'd1);
      check("R1", "err after reset", 32'(err), 32'd0);
      q_gid = 4'd1;
      #1;
      check("R1", "unallocated id 1 valid", 32'(q_valid), 32'd0);
      check("R1", "unallocated id 1 status", 32'(stat()), 32'd0);
      q_gid = 4'd5;
      #1;
      check("R1", "unallocated id 5 valid", 32'(q_valid), 32'd0);

      // R11 event lands on the edge, not before
      @(negedge clk);
      ev_valid = 1'b1;
      ev_op    = 3'd1;
      q_gid    = 4'd1;
      #1;
      check("R11", "next_gid before edge", 32'(next_gid), 32'd1);
      check("R11", "group 1 valid before edge", 32'(q_valid), 32'd0);
      @(negedge clk);
      ev_valid = 1'b0;
      #1;
      check("R11", "next_gid after edge", 32'(next_gid), 32'd2);
      check("R11", "group 1 valid after edge", 32'(q_valid), 32'd1);
      q_gid = 4'd2;
      #0.5;
      check("R11", "query follows q_gid without a clock", 32'(q_valid), 32'd0);

      // R2 pool exhaustion
      for (int i = 0; i < NG - 1; i++) send(3'd1, '0, '0, '0);
      #1;
      check("R2", "next_gid after filling pool", 32'(next_gid), 32'(NG + 1));
      check("R2", "err after filling pool", 32'(err), 32'd0);
      q_gid = 4'(NG);
      #1;
      check("R2", "last id valid", 32'(q_valid), 32'd1);
      send(3'd1, '0, '0, '0);
      #1;
      check("R2", "err on alloc beyond pool", 32'(err), 32'd1);
      check("R2", "next_gid held when pool full", 32'(next_gid), 32'(NG + 1));

      // R10 reserved op codes and stickiness
      do_reset();
      send(3'd7, '0, '0, '0);
      #1;
      check("R10", "err on op 7", 32'(err), 32'd1);
      repeat (5) @(negedge clk);
      #1;
      check("R10", "err stays set", 32'(err), 32'd1);
      do_reset();
      send(3'd0, '0, '0, '0);
      #1;
      check("R10", "err on op 0", 32'(err), 32'd1);

      // R9 and the full chain, from a clean reset
      do_reset();
      for (int i = 0; i < NV; i++) begin
         e = VEC[i];
         @(negedge clk);
         ev_valid = e[34];
         ev_op    = e[33:31];
         ev_gid   = e[30:27];
         ev_dst   = e[26:23];
         ev_cyc   = e[22:17];
         @(negedge clk);
         ev_valid = 1'b0;
         q_gid    = e[16:13];
         #1;
         check(req_of(e[34], e[33:31]), $sformatf("step %0d valid", i), 32'(q_valid), 32'(e[12]));
         check(req_of(e[34], e[33:31]), $sformatf("step %0d status", i), 32'(stat()), 32'(e[11:7]));
         check("R8", $sformatf("step %0d crit", i), 32'(q_crit), 32'(e[6:1]));
         check(i >= 27 ? "R9" : "R10", $sformatf("step %0d err", i), 32'(err), 32'(e[0]));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule